// File: doc/BRIEF.md
# Audio Subframe Packer

This block is a streaming formatter. It turns audio sample words into the 32-bit subframe words that a digital audio transmitter expects. Words come in and leave on valid/ready streams, one word per channel, with the channels of a frame in order. A configuration input picks the mode for the whole stream. In linear mode the block takes a 24-bit sample and adds three things: a channel status bit drawn from a 192-frame status block, a flag that marks the start of that block, and an even parity bit. In pre-formatted mode the input word already carries its flags, sample and preamble code, and the block only moves those fields to the positions the transmitter uses.

Before a stream starts, the controlling logic sets the channel count (2 to 8), the mode and four channel status bytes, and then raises a one-cycle start pulse. The pulse latches the count and the status bytes and sets the frame and channel position to zero. The output has a single register stage. It accepts a new word whenever that stage is empty or is being drained, so a continuous stream flows at one word per clock.

Top module: `subframe_packer`

## Requirements
- R1: In linear mode, output bits 23..0 equal input bits 23..0. The input bits 31..24 are dropped, and output bits 25..24 and 31..29 are zero. Bits 31..29 are zero in both modes.
- R2: In linear mode, output bit 26 is the status bit for the current frame. For frames 0..31 it is bit (frame mod 8) of status byte (frame div 8), where byte k is `cs_bytes_i[8k+7:8k]`. Frames 32..191 carry 0.
- R3: Frames 20..23 (byte 2, bits 4..7) do not use the loaded bits. They carry bits 0..3 of the channel index plus one, so channel 0 sends 1.
- R4: In linear mode, output bit 27 makes the number of ones in output bits 27..0 even.
- R5: In linear mode, output bit 28 is 1 only for channel 0 of frame 0 and is 0 for every other word.
- R6: The channel index steps on each accepted word. After the last configured channel it returns to 0 and the frame number steps, wrapping from 191 to 0.
- R7: The channel count and the status bytes are sampled on the start pulse; later changes have no effect until the next pulse. A count outside 2..8 is treated as 2.
- R8: In pre-formatted mode, output bits 27..0 equal input bits 31..4, output bit 28 equals input bit 3, and bits 31..29 are zero.
- R9: A start pulse sets the frame and channel to 0, so the next accepted word is channel 0 of frame 0. `in_ready_o` is low in the start cycle.
- R10: `in_ready_o` is high whenever the output stage is empty or `out_ready_i` is high, and the start pulse is low. A stalled output word stays valid and unchanged. Under continuous flow, n words pass in n+1 cycles.
- R11: After reset the output is not valid, input is ready, the position is channel 0 of frame 0, the count is 2 and all status bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse: clear the position, latch count and status bytes |
| mode_i | input | 1 | 0 = linear samples, 1 = pre-formatted words; held for a whole stream |
| chan_count_i | input | 4 | Channels per frame, 2..8 |
| cs_bytes_i | input | 32 | Channel status bytes 0..3, byte k in bits 8k+7..8k |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 32 | Input word |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 32 | Packed subframe word |
| out_ready_i | input | 1 | Downstream accepts the output word |

## Verification
A wrong channel index or frame number corrupts the status bit, the parity bit or the block-start flag, and this shows at the ports on the first word where that bit differs. A channel index that is off by one misplaces the block-start flag by one word, at the latest one frame after the fault. A wrong wrap limit first shows at the next block boundary, up to 192 frames later. That is why the streams run across a full block and past it for the largest channel count.

Status bytes and counts that are not latched correctly show only after the inputs change without a new start pulse, so the bench changes them in the middle of a stream. A fault in the output stage shows one cycle after a stall, as a word that changes or disappears while `out_ready_i` is low.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
    localparam int WORD_W      = 32;
    localparam int SAMPLE_W    = 24;
    localparam int STATUS_BIT  = 26;
    localparam int PARITY_BIT  = 27;
    localparam int BLOCK_BIT   = 28;
    localparam int PRE_SHIFT   = 4;
    localparam int PRE_BLK_IN  = 3;
    localparam int CHNUM_LO    = 20;
    localparam int CHNUM_BITS  = 4;

    typedef enum logic {
        MODE_LINEAR = 1'b0,
        MODE_PREFMT = 1'b1
    } sf_mode_e;
endpackage

// File: rtl/sfp_position.sv
module sfp_position #(
    parameter int FRAMES = 192,
    parameter int MAX_CH = 8,
    localparam int FRAME_W = $clog2(FRAMES),
    localparam int CH_W    = $clog2(MAX_CH),
    localparam int CNT_W   = $clog2(MAX_CH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               step_i,
    input  logic [CNT_W-1:0]   nch_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CH_W-1:0]    chan_o,
    output logic               first_o
);
    localparam logic [FRAME_W-1:0] FRAME_LAST = FRAME_W'(FRAMES - 1);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [CH_W-1:0]    chan;
        logic [CH_W-1:0]    last;
    } pos_t;

    pos_t pos_d, pos_q;
    logic [CNT_W-1:0] nch_ok;

    always_comb begin
        if (nch_i < CNT_W'(2) || nch_i > CNT_W'(MAX_CH))
            nch_ok = CNT_W'(2);
        else
            nch_ok = nch_i;

        pos_d = pos_q;
        if (clear_i) begin
            pos_d.frame = '0;
            pos_d.chan  = '0;
            pos_d.last  = CH_W'(nch_ok - CNT_W'(1));
        end else if (step_i) begin
            if (pos_q.chan == pos_q.last) begin
                pos_d.chan  = '0;
                pos_d.frame = (pos_q.frame == FRAME_LAST) ? '0 : pos_q.frame + 1'b1;
            end else begin
                pos_d.chan = pos_q.chan + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q.frame <= '0;
            pos_q.chan  <= '0;
            pos_q.last  <= CH_W'(1);
        end else begin
            pos_q <= pos_d;
        end
    end

    assign frame_o = pos_q.frame;
    assign chan_o  = pos_q.chan;
    assign first_o = (pos_q.frame == '0) && (pos_q.chan == '0);
endmodule

// File: rtl/sfp_status_sel.sv
module sfp_status_sel
    import sfp_pkg::*;
#(
    parameter int CS_BYTES = 4,
    parameter int FRAME_W  = 8,
    parameter int CH_W     = 3,
    localparam int CS_BITS = CS_BYTES * 8
) (
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [CH_W-1:0]    chan_i,
    input  logic [CS_BITS-1:0] cs_i,
    output logic               bit_o
);
    logic [CHNUM_BITS-1:0] chnum;

    always_comb begin
        chnum = CHNUM_BITS'(chan_i) + CHNUM_BITS'(1);
        bit_o = 1'b0;
        for (int k = 0; k < CS_BITS; k++) begin
            if (frame_i == FRAME_W'(k))
                bit_o = cs_i[k];
        end
        for (int k = 0; k < CHNUM_BITS; k++) begin
            if (frame_i == FRAME_W'(CHNUM_LO + k))
                bit_o = chnum[k];
        end
    end
endmodule

// File: rtl/sfp_word_fmt.sv
module sfp_word_fmt
    import sfp_pkg::*;
(
    input  sf_mode_e            mode_i,
    input  logic [WORD_W-1:0]   data_i,
    input  logic                cs_bit_i,
    input  logic                first_i,
    output logic [WORD_W-1:0]   word_o
);
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] lin;

    always_comb begin
        shifted = data_i >> PRE_SHIFT;
        lin = '0;
        lin[SAMPLE_W-1:0] = data_i[SAMPLE_W-1:0];
        lin[STATUS_BIT]   = cs_bit_i;
        lin[PARITY_BIT]   = ^{cs_bit_i, data_i[SAMPLE_W-1:0]};
        lin[BLOCK_BIT]    = first_i;
        if (mode_i == MODE_PREFMT) begin
            word_o = shifted;
            word_o[BLOCK_BIT] = data_i[PRE_BLK_IN];
        end else begin
            word_o = lin;
        end
    end
endmodule

// File: rtl/subframe_packer.sv
module subframe_packer
    import sfp_pkg::*;
#(
    parameter int FRAMES_PER_BLOCK = 192,
    parameter int CS_BYTES         = 4,
    parameter int MAX_CH           = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start_i,
    input  logic                             mode_i,
    input  logic [$clog2(MAX_CH + 1)-1:0]    chan_count_i,
    input  logic [CS_BYTES*8-1:0]            cs_bytes_i,
    input  logic                             in_valid_i,
    input  logic [31:0]                      in_data_i,
    output logic                             in_ready_o,
    output logic                             out_valid_o,
    output logic [31:0]                      out_data_o,
    input  logic                             out_ready_i
);
    localparam int FRAME_W = $clog2(FRAMES_PER_BLOCK);
    localparam int CH_W    = $clog2(MAX_CH);
    localparam int CS_BITS = CS_BYTES * 8;

    typedef struct packed {
        logic [CS_BITS-1:0] cs;
        logic               out_valid;
        logic [WORD_W-1:0]  out_data;
    } top_t;

    top_t st_d, st_q;

    logic [FRAME_W-1:0] frame;
    logic [CH_W-1:0]    chan;
    logic               first;
    logic               cs_bit;
    logic [WORD_W-1:0]  word;
    logic               accept;

    assign in_ready_o = !start_i && (!st_q.out_valid || out_ready_i);
    assign accept     = in_valid_i && in_ready_o;

    sfp_position #(
        .FRAMES (FRAMES_PER_BLOCK),
        .MAX_CH (MAX_CH)
    ) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .step_i  (accept),
        .nch_i   (chan_count_i),
        .frame_o (frame),
        .chan_o  (chan),
        .first_o (first)
    );

    sfp_status_sel #(
        .CS_BYTES (CS_BYTES),
        .FRAME_W  (FRAME_W),
        .CH_W     (CH_W)
    ) u_sel (
        .frame_i (frame),
        .chan_i  (chan),
        .cs_i    (st_q.cs),
        .bit_o   (cs_bit)
    );

    sfp_word_fmt u_fmt (
        .mode_i   (sf_mode_e'(mode_i)),
        .data_i   (in_data_i),
        .cs_bit_i (cs_bit),
        .first_i  (first),
        .word_o   (word)
    );

    always_comb begin
        st_d = st_q;
        if (start_i)
            st_d.cs = cs_bytes_i;
        if (accept) begin
            st_d.out_valid = 1'b1;
            st_d.out_data  = word;
        end else if (out_ready_i) begin
            st_d.out_valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid_o = st_q.out_valid;
    assign out_data_o  = st_q.out_data;
endmodule

// File: rtl/sfp_checker.sv
module sfp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        mode_i,
    input logic        in_ready_o,
    input logic        out_valid_o,
    input logic [31:0] out_data_o,
    input logic        out_ready_i
);
    p_hold_on_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

    p_ready_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o && !start_i |-> in_ready_o);

    p_no_accept_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !in_ready_o);

    p_top_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> out_data_o[31:29] == 3'b000);

    p_spare_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !mode_i |-> out_data_o[25:24] == 2'b00);

    p_even_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !mode_i |-> ^out_data_o[27:0] == 1'b0);
endmodule

bind subframe_packer sfp_checker u_chk (.*);

// File: tb/subframe_packer_test.sv
module subframe_packer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [3:0]  chan_count_i = 4'd2;
    logic [31:0] cs_bytes_i = '0;
    logic        in_valid_i = 1'b0;
    logic [31:0] in_data_i = '0;
    logic        in_ready_o;
    logic        out_valid_o;
    logic [31:0] out_data_o;
    logic        out_ready_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    subframe_packer uut (.*);

    // pre-formatted vectors: {input, expected}
    localparam logic [63:0] PRE_VEC [6] = '{
        {32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'h1FFF_FFFF},
        {32'h1234_5678, 32'h1123_4567},
        {32'hABCD_EF04, 32'h0ABC_DEF0},
        {32'h8000_0008, 32'h1800_0000},
        {32'h0000_0012, 32'h0000_0001}
    };

    logic [31:0] exp_q [$];
    int          frm_q [$];
    int frame_m, chan_m, nch_m;
    logic [31:0] cs_m;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input bit md, input logic [31:0] d,
                                          input int fr, input int ch, input logic [31:0] cs);
        logic [31:0] w;
        logic [3:0] cn;
        logic sb;
        if (md) return {3'b000, d[3], d[31:4]};
        cn = 4'(ch + 1);
        if (fr >= 20 && fr <= 23) sb = cn[fr-20];   // R3
        else if (fr < 32)         sb = cs[fr];      // R2
        else                      sb = 1'b0;
        w = {8'h00, d[23:0]};
        w[26] = sb;
        w[27] = ^w[26:0];                            // R4
        w[28] = (fr == 0 && ch == 0);                // R5
        return w;
    endfunction

    task automatic cmp_word(input logic [31:0] a, input logic [31:0] e, input int fr,
                            input bit md, input string tag);
        if (md) begin
            check(a == e, {"R8 ", tag}, a, e);
        end else begin
            check(a[23:0] == e[23:0], {"R1 sample ", tag}, a, e);
            check({a[31:29], a[25:24]} == 5'b0, {"R1 zero bits ", tag}, a, e);
            check(a[26] == e[26], (fr >= 20 && fr <= 23) ? {"R3 ", tag} : {"R2 ", tag}, a, e);
            check(a[27] == e[27], {"R4 ", tag}, a, e);
            check(a[28] == e[28], {"R5 R6 ", tag}, a, e);
        end
    endtask

    task automatic stream(input int n, input bit md, input int nraw, input logic [31:0] cs,
                          input bit stall, input string tag, input bit relatch);
        int sent = 0, rcvd = 0, iter = 0;
        bit held = 0;
        logic [31:0] hd = '0;
        @(negedge clk);
        mode_i = md; chan_count_i = 4'(nraw); cs_bytes_i = cs; start_i = 1'b1;
        #1 check(in_ready_o == 1'b0, "R9 ready low on start", {31'b0, in_ready_o}, 32'h0);
        @(negedge clk);
        start_i = 1'b0;
        if (relatch) begin   // R7: changes after the pulse must be ignored
            chan_count_i = 4'd3; cs_bytes_i = ~cs;
        end
        frame_m = 0; chan_m = 0; cs_m = cs;
        nch_m = (nraw < 2 || nraw > 8) ? 2 : nraw;
        while (rcvd < n) begin
            if (held)
                check(out_valid_o && out_data_o == hd, "R10 stall hold", out_data_o, hd);
            out_ready_i = stall ? (iter % 3 != 1) : 1'b1;
            in_valid_i  = (sent < n) && (stall ? (iter % 5 != 2) : 1'b1);
            in_data_i   = 32'(sent) * 32'h9E37_79B1 + 32'h0123_4567;
            #1;
            if (out_valid_o && out_ready_i) begin
                cmp_word(out_data_o, exp_q.pop_front(), frm_q.pop_front(), md, tag);
                rcvd++;
            end
            held = out_valid_o && !out_ready_i;
            hd = out_data_o;
            if (in_valid_i && in_ready_o) begin
                exp_q.push_back(model(md, in_data_i, frame_m, chan_m, cs_m));
                frm_q.push_back(frame_m);
                if (chan_m == nch_m - 1) begin   // R6
                    chan_m = 0;
                    frame_m = (frame_m == 191) ? 0 : frame_m + 1;
                end else chan_m++;
                sent++;
            end
            iter++;
            @(negedge clk);
        end
        in_valid_i = 1'b0; out_ready_i = 1'b1;
        if (!stall)
            check(iter == n + 1, {"R10 no bubbles ", tag}, 32'(iter), 32'(n + 1));
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(out_valid_o == 1'b0, "R11 out_valid after reset", {31'b0, out_valid_o}, 32'h0);
        check(in_ready_o == 1'b1, "R11 in_ready after reset", {31'b0, in_ready_o}, 32'h1);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: first word after reset without start: frame 0, channel 0, status zero
        @(negedge clk);
        in_valid_i = 1'b1; in_data_i = 32'hFF00_0001;
        @(negedge clk);
        in_valid_i = 1'b0;
        #1 check(out_valid_o && out_data_o == 32'h1800_0001, "R11 first word", out_data_o, 32'h1800_0001);

        // R8: pre-formatted vector table
        mode_i = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid_i = 1'b1; in_data_i = PRE_VEC[i][63:32];
            @(negedge clk);
            in_valid_i = 1'b0;
            #1 check(out_valid_o && out_data_o == PRE_VEC[i][31:0], "R8 table",
                     out_data_o, PRE_VEC[i][31:0]);
        end
        @(negedge clk);

        stream(400, 1'b0, 2, 32'h5AF0_C3A5, 1'b0, "two ch", 1'b0);
        stream(1546, 1'b0, 8, 32'h1357_9BDF, 1'b1, "R7 eight ch relatch", 1'b1);
        stream(390, 1'b0, 9, 32'h0F0F_F0F0, 1'b0, "R7 count 9", 1'b0);
        stream(20, 1'b0, 1, 32'hFFFF_FFFF, 1'b0, "R7 count 1", 1'b0);
        stream(50, 1'b0, 5, 32'hA5A5_A5A5, 1'b1, "five ch", 1'b0);
        stream(30, 1'b0, 5, 32'h0000_0000, 1'b0, "R9 restart", 1'b0);
        stream(40, 1'b1, 2, 32'h0, 1'b1, "pre stall", 1'b0);

        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule